// File: doc/BRIEF.md
# Trigger-Gated Waveform Packetizer

This block sits behind the deserializer of one ADC channel. The channel's 12-bit samples arrive as two parallel lanes at half the sample rate: lane 0 carries the even samples and lane 1 the odd ones, one pair per clock. The stream runs without a break. The block keeps only the short windows of it that belong to an accepted trigger and throws every other sample away.

Each accepted trigger produces one packet. The first word is a header that holds a running trigger number and a coarse time-of-flight value. That value is the number of clocks counted from the most recent start pulse up to the trigger. A fixed number of sample words follows the header, taken from the clock cycles right after the trigger, with the two lanes merged back into sample order. Packet words go into an internal buffer that can take two words per clock. They leave through a ready/valid port toward a downstream FIFO, with flags that mark the header and the final word of each packet. A trigger is refused in two cases: when a cell is still being captured, and when the buffer cannot hold a whole packet. Every refused trigger adds one to a saturating counter.

Top module: `trig_wave_packer`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `drop_count` go to zero at the next clock edge. The time counter, the trigger number and the buffer also clear.
- R2: A trigger is accepted in a cycle when no cell is being captured and the buffer holds at most DEPTH-CELL_WORDS-1 words. The accepted trigger writes one header word in that cycle. The header has `out_first`=1 and `out_last`=0, and its data is {trigger number in bits [ID_W+TIME_W-1:TIME_W], time count in bits [TIME_W-1:0]}, zero-extended.
- R3: After an accepted trigger in cycle T, the cycles T+1 to T+CELL_WORDS/2 are captured. Each captured cycle writes two sample words: the lane 0 sample first, then the lane 1 sample. Each sample is zero-extended. `out_last`=1 only on the lane 1 word of cycle T+CELL_WORDS/2.
- R4: No sample from any cycle outside a capture window reaches the output.
- R5: The first trigger accepted after reset carries trigger number 0. Each accepted trigger adds one, and the number wraps to 0 after its all-ones value.
- R6: The time counter is 0 after reset. After a cycle with `t0_pulse` high it becomes 0; in every other cycle it adds one, and it holds at all-ones instead of wrapping. A header carries the value the counter held during the trigger cycle, so a start pulse in that same cycle does not affect that header.
- R7: A trigger that arrives in any capture cycle, the last one included, is ignored and adds one to `drop_count`.
- R8: A trigger that arrives while no cell is being captured but the buffer holds more than DEPTH-CELL_WORDS-1 words is rejected and adds one to `drop_count`.
- R9: `drop_count` saturates at its all-ones value.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_first` and `out_last` hold. Words leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-pair clock |
| rst_n | input | 1 | Synchronous active-low reset |
| t0_pulse | input | 1 | Start pulse; restarts the time-of-flight count |
| trig_in | input | 1 | Trigger request (the stop event) |
| lane0_sample | input | SAMPLE_W | Even-indexed sample of the current pair |
| lane1_sample | input | SAMPLE_W | Odd-indexed sample of the current pair |
| out_ready | input | 1 | Downstream can take a word |
| out_valid | output | 1 | A packet word is offered |
| out_data | output | max(ID_W+TIME_W, SAMPLE_W) | Header or sample word |
| out_first | output | 1 | Offered word is a header |
| out_last | output | 1 | Offered word is the final sample of a packet |
| drop_count | output | DROP_W | Saturating count of refused triggers |

## Verification
The checker tests these rules on every clock:
- the output holds while it is stalled;
- the trigger number steps by one on each acceptance;
- the time count clears after a start pulse and sticks at all-ones;
- `drop_count` rises after a trigger that lands in a capture, and sticks once saturated;
- the buffer never holds more than its depth, and no trigger is accepted without room for a whole packet.

Other behaviour shows up only in the bench's scenarios:
- the sample order and the exact capture window;
- which cycle a trigger falls in relative to an earlier one;
- the header time when a start pulse and a trigger share a cycle;
- the busy rejection reached by stalling the output.

The bench runs these against its own queue of expected words.

// File: rtl/trig_wave_pkg.sv
// Package: types and helpers shared by the packetizer and its sub-blocks.
package trig_wave_pkg;

    // Capture sequencer state.
    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_RUN  = 1'b1
    } cap_state_e;

    // Larger of two widths, used to size the packet word.
    function automatic int wider(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tof_stamp.sv
// Module: tof_stamp
// Keeps the two values that go into a packet header: a coarse time count
// and a trigger number.
// The time count restarts after a start pulse, rises once per clock and
// holds at all-ones. The trigger number rises once per accepted trigger
// and wraps.
// Assumes: accept is high for one cycle per accepted trigger.
module tof_stamp #(
    parameter int ID_W   = 16,
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              t0_pulse,
    input  logic              accept,
    output logic [TIME_W-1:0] tof,
    output logic [ID_W-1:0]   trig_id
);

    // Coarse time-of-flight counter: clear on start, otherwise saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tof <= '0;
        end else if (t0_pulse) begin
            tof <= '0;
        end else if (!(&tof)) begin
            tof <= tof + TIME_W'(1);
        end
    end

    // Trigger number: wrapping increment on each accepted trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_id <= '0;
        end else if (accept) begin
            trig_id <= trig_id + ID_W'(1);
        end
    end

endmodule

// File: rtl/trig_gate.sv
// Module: trig_gate
// Decides whether a trigger is accepted, runs the capture window that
// follows it, and counts refused triggers with a saturating counter.
// Assumes: PAIRS >= 1. space_ok means the buffer can hold one whole packet.
module trig_gate
    import trig_wave_pkg::*;
#(
    parameter int PAIRS  = 32,
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic              space_ok,
    output logic              accept,
    output logic              capturing,
    output logic              last_pair,
    output logic [DROP_W-1:0] drop_count
);

    localparam int PW = (PAIRS > 1) ? $clog2(PAIRS) : 1;
    localparam logic [PW-1:0] LAST_IDX = PW'(PAIRS - 1);

    cap_state_e     state;
    logic [PW-1:0]  pair_idx;
    logic           refuse;

    // Acceptance and status decode for the current cycle.
    always_comb begin
        capturing = (state == CAP_RUN);
        last_pair = capturing && (pair_idx == LAST_IDX);
        accept    = trig_in && !capturing && space_ok;
        refuse    = trig_in && !accept;
    end

    // Capture sequencer: one window of PAIRS cycles after each acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CAP_IDLE;
            pair_idx <= '0;
        end else if (accept) begin
            state    <= CAP_RUN;
            pair_idx <= '0;
        end else if (capturing) begin
            if (last_pair) begin
                state <= CAP_IDLE;
            end
            pair_idx <= pair_idx + PW'(1);
        end
    end

    // Refused-trigger counter, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_count <= '0;
        end else if (refuse && !(&drop_count)) begin
            drop_count <= drop_count + DROP_W'(1);
        end
    end

endmodule

// File: rtl/cell_fifo.sv
// Module: cell_fifo
// Show-ahead buffer that takes up to two entries per clock (port A, then
// port B) and gives out one per clock.
// space_ok reports that at least SPACE_NEED entries are free.
// Assumes: DEPTH is a power of two, DEPTH >= SPACE_NEED, and wr_b is only
// high together with wr_a.
module cell_fifo #(
    parameter int ENTRY_W    = 50,
    parameter int DEPTH      = 256,
    parameter int SPACE_NEED = 65
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_a,
    input  logic [ENTRY_W-1:0]         data_a,
    input  logic                       wr_b,
    input  logic [ENTRY_W-1:0]         data_b,
    input  logic                       rd_req,
    output logic [ENTRY_W-1:0]         head,
    output logic                       not_empty,
    output logic [$clog2(DEPTH+1)-1:0] fill,
    output logic                       space_ok
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DEPTH - SPACE_NEED);

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [AW-1:0]      wr_ptr;
    logic [AW-1:0]      rd_ptr;
    logic               rd_go;

    // Read side and status decode.
    always_comb begin
        not_empty = (fill != '0);
        rd_go     = rd_req && not_empty;
        head      = mem[rd_ptr];
        space_ok  = (fill <= LIMIT);
    end

    // Storage writes: port A at the write pointer, port B one slot after it.
    always_ff @(posedge clk) begin
        if (wr_a) begin
            mem[wr_ptr] <= data_a;
        end
        if (wr_b) begin
            mem[wr_ptr + AW'(1)] <= data_b;
        end
    end

    // Pointer and fill bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(wr_a) + AW'(wr_b);
            rd_ptr <= rd_ptr + AW'(rd_go);
            fill   <= fill + CW'(wr_a) + CW'(wr_b) - CW'(rd_go);
        end
    end

endmodule

// File: rtl/trig_wave_packer.sv
// Module: trig_wave_packer (top)
// Cuts fixed-length cells out of a two-lane sample stream when a trigger
// is accepted, puts a header holding the trigger number and the time of
// flight in front of each cell, and streams the packet words out over
// ready/valid.
// Assumes: CELL_WORDS is even, DEPTH is a power of two and
// DEPTH >= CELL_WORDS + 1.
module trig_wave_packer
    import trig_wave_pkg::*;
#(
    parameter int SAMPLE_W   = 12,
    parameter int CELL_WORDS = 64,
    parameter int ID_W       = 16,
    parameter int TIME_W     = 32,
    parameter int DEPTH      = 256,
    parameter int DROP_W     = 16,
    localparam int HDR_W     = ID_W + TIME_W,
    localparam int WORD_W    = wider(HDR_W, SAMPLE_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                t0_pulse,
    input  logic                trig_in,
    input  logic [SAMPLE_W-1:0] lane0_sample,
    input  logic [SAMPLE_W-1:0] lane1_sample,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [WORD_W-1:0]   out_data,
    output logic                out_first,
    output logic                out_last,
    output logic [DROP_W-1:0]   drop_count
);

    localparam int PAIRS   = CELL_WORDS / 2;
    localparam int ENTRY_W = WORD_W + 2;
    localparam int CW      = $clog2(DEPTH + 1);

    logic               accept;
    logic               cap_busy;
    logic               last_pair;
    logic               space_ok;
    logic [TIME_W-1:0]  tof;
    logic [ID_W-1:0]    trig_id;
    logic [CW-1:0]      fill_count;
    logic               wr_a;
    logic               wr_b;
    logic [ENTRY_W-1:0] data_a;
    logic [ENTRY_W-1:0] data_b;
    logic [ENTRY_W-1:0] head;

    tof_stamp #(
        .ID_W   (ID_W),
        .TIME_W (TIME_W)
    ) u_stamp (
        .clk      (clk),
        .rst_n    (rst_n),
        .t0_pulse (t0_pulse),
        .accept   (accept),
        .tof      (tof),
        .trig_id  (trig_id)
    );

    trig_gate #(
        .PAIRS  (PAIRS),
        .DROP_W (DROP_W)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_in    (trig_in),
        .space_ok   (space_ok),
        .accept     (accept),
        .capturing  (cap_busy),
        .last_pair  (last_pair),
        .drop_count (drop_count)
    );

    // Write-side packing: header on acceptance, otherwise a lane pair while capturing.
    always_comb begin
        wr_a   = accept || cap_busy;
        wr_b   = cap_busy;
        data_a = accept ? {1'b1, 1'b0, WORD_W'({trig_id, tof})}
                        : {1'b0, 1'b0, WORD_W'(lane0_sample)};
        data_b = {1'b0, last_pair, WORD_W'(lane1_sample)};
    end

    cell_fifo #(
        .ENTRY_W    (ENTRY_W),
        .DEPTH      (DEPTH),
        .SPACE_NEED (CELL_WORDS + 1)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_a      (wr_a),
        .data_a    (data_a),
        .wr_b      (wr_b),
        .data_b    (data_b),
        .rd_req    (out_ready),
        .head      (head),
        .not_empty (out_valid),
        .fill      (fill_count),
        .space_ok  (space_ok)
    );

    // Output unpacking of the entry at the head of the buffer.
    always_comb begin
        out_first = head[ENTRY_W-1];
        out_last  = head[ENTRY_W-2];
        out_data  = head[WORD_W-1:0];
    end

endmodule

// File: rtl/trig_wave_packer_checks.sv
// Module: trig_wave_packer_checks
// Cycle-by-cycle properties of the packetizer, bound to the top module.
module trig_wave_packer_checks #(
    parameter int ID_W       = 16,
    parameter int TIME_W     = 32,
    parameter int WORD_W     = 48,
    parameter int DEPTH      = 256,
    parameter int CELL_WORDS = 64,
    parameter int DROP_W     = 16,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              t0_pulse,
    input logic              trig_in,
    input logic              out_ready,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_data,
    input logic              out_first,
    input logic              out_last,
    input logic [DROP_W-1:0] drop_count,
    input logic              accept,
    input logic              capturing,
    input logic [TIME_W-1:0] tof,
    input logic [ID_W-1:0]   trig_id,
    input logic [CW-1:0]     fill_count
);

    localparam logic [CW-1:0] ROOM_LIM = CW'(DEPTH - CELL_WORDS - 1);
    localparam logic [CW-1:0] FULL_LIM = CW'(DEPTH);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && drop_count == '0)); // R1

    AST_HEADER_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_first) |-> !out_last); // R2

    AST_ID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (trig_id == ID_W'($past(trig_id) + 1'b1))); // R5

    AST_TOF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        t0_pulse |=> (tof == '0)); // R6

    AST_TOF_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!t0_pulse && (&tof)) |=> (&tof)); // R6

    AST_DROP_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_in && capturing && !(&drop_count))
            |=> (drop_count == DROP_W'($past(drop_count) + 1'b1))); // R7

    AST_ROOM_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (fill_count <= ROOM_LIM)); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= FULL_LIM); // R8

    AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (&drop_count) |=> (&drop_count)); // R9

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
            && $stable(out_first) && $stable(out_last))); // R10

endmodule

bind trig_wave_packer trig_wave_packer_checks #(
    .ID_W       (ID_W),
    .TIME_W     (TIME_W),
    .WORD_W     (WORD_W),
    .DEPTH      (DEPTH),
    .CELL_WORDS (CELL_WORDS),
    .DROP_W     (DROP_W)
) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .t0_pulse   (t0_pulse),
    .trig_in    (trig_in),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_first  (out_first),
    .out_last   (out_last),
    .drop_count (drop_count),
    .accept     (accept),
    .capturing  (cap_busy),
    .tof        (tof),
    .trig_id    (trig_id),
    .fill_count (fill_count)
);

// File: tb/trig_wave_packer_test.sv
// Bench: small configuration, expected packet words kept in a queue built
// from the requirements, and compared with the output on every cycle.
module trig_wave_packer_test;

    localparam int SW    = 12;
    localparam int CELLS = 4;
    localparam int IDW   = 4;
    localparam int TW    = 8;
    localparam int DEP   = 16;
    localparam int DW    = 3;
    localparam int WW    = (IDW + TW > SW) ? IDW + TW : SW;
    localparam int PAIRS = CELLS / 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          t0_pulse;
    logic          trig_in;
    logic [SW-1:0] lane0_sample;
    logic [SW-1:0] lane1_sample;
    logic          out_ready;
    logic          out_valid;
    logic [WW-1:0] out_data;
    logic          out_first;
    logic          out_last;
    logic [DW-1:0] drop_count;

    always #10 clk = ~clk;

    trig_wave_packer #(
        .SAMPLE_W   (SW),
        .CELL_WORDS (CELLS),
        .ID_W       (IDW),
        .TIME_W     (TW),
        .DEPTH      (DEP),
        .DROP_W     (DW)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .t0_pulse     (t0_pulse),
        .trig_in      (trig_in),
        .lane0_sample (lane0_sample),
        .lane1_sample (lane1_sample),
        .out_ready    (out_ready),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_first    (out_first),
        .out_last     (out_last),
        .drop_count   (drop_count)
    );

    int             n_chk = 0;
    int             n_fail = 0;
    bit             done = 1'b0;
    logic [WW+1:0]  expq [$];
    int             k = 0;
    int             cap_left = 0;
    logic [IDW-1:0] m_id = '0;
    logic [TW-1:0]  m_time = '0;
    logic [DW-1:0]  m_drop = '0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive inputs, compare outputs, then advance the model.
    task automatic step(input bit trg, input bit t0v, input bit rdy);
        int occ;
        bit capn;
        bit acc;
        @(negedge clk);
        trig_in      = trg;
        t0_pulse     = t0v;
        out_ready    = rdy;
        lane0_sample = SW'(2 * k);
        lane1_sample = SW'(2 * k + 1);
        #1;
        chk(out_valid == (expq.size() != 0), "R4 R10 out_valid", out_valid, expq.size() != 0);
        if (out_valid && expq.size() != 0) begin
            chk({out_first, out_last, out_data} == expq[0],
                expq[0][WW+1] ? "R2 R5 R6 header word" : "R3 sample word",
                {out_first, out_last, out_data}, expq[0]);
        end
        chk(drop_count == m_drop, "R7 R8 R9 drop_count", drop_count, m_drop);
        occ = expq.size();
        if (out_valid && rdy && occ != 0) begin
            void'(expq.pop_front());
        end
        capn = (cap_left > 0);
        acc  = trg && !capn && (DEP - occ >= CELLS + 1);
        if (capn) begin
            expq.push_back({2'b00, WW'(SW'(2 * k))});
            expq.push_back({1'b0, cap_left == 1, WW'(SW'(2 * k + 1))});
            cap_left--;
        end
        if (acc) begin
            expq.push_back({2'b10, WW'({m_id, m_time})});
            m_id     = m_id + 1'b1;
            cap_left = PAIRS;
        end else if (trg && !(&m_drop)) begin
            m_drop = m_drop + 1'b1;
        end
        if (t0v) begin
            m_time = '0;
        end else if (!(&m_time)) begin
            m_time = m_time + 1'b1;
        end
        k++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 1'b0, 1'b1);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n        = 1'b0;
        t0_pulse     = 1'b0;
        trig_in      = 1'b0;
        out_ready    = 1'b1;
        lane0_sample = '0;
        lane1_sample = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
        chk(drop_count == '0, "R1 reset drop_count", drop_count, 0);
        @(negedge clk);
        rst_n  = 1'b1;
        m_time = TW'(1); // one edge passes before the first step

        // R4: stream with no trigger gives no words
        idle(8);

        // R2 R3 R6: start pulse, then one trigger
        step(1'b0, 1'b1, 1'b1);
        idle(5);
        step(1'b1, 1'b0, 1'b1);
        idle(6);

        // R7: trigger spacing sweep across the capture window
        for (int gap = 0; gap < 6; gap++) begin
            step(1'b1, 1'b0, 1'b1);
            idle(gap);
        end
        idle(6);

        // R5: enough accepted triggers to wrap the trigger number
        for (int i = 0; i < 18; i++) begin
            step(1'b1, 1'b0, 1'b1);
            idle(3);
        end

        // R6: time count saturates
        idle(300);
        step(1'b1, 1'b0, 1'b1);
        idle(6);

        // R6: start pulse in the trigger cycle keeps the old time in the header
        step(1'b0, 1'b1, 1'b1);
        idle(3);
        step(1'b1, 1'b1, 1'b1);
        idle(6);

        // R8 R10: stalled output fills the buffer, fourth trigger is busy
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 1'b0, 1'b0);
            for (int j = 0; j < 3; j++) begin
                step(1'b0, 1'b0, 1'b0);
            end
        end
        for (int i = 0; i < 45; i++) begin
            step(1'b0, 1'b0, (i % 3) != 0);
        end

        // R9: held trigger saturates the drop counter
        for (int i = 0; i < 30; i++) begin
            step(1'b1, 1'b0, 1'b1);
        end
        idle(12);
        #1;
        chk(drop_count == {DW{1'b1}}, "R9 drop_count saturated", drop_count, {DW{1'b1}});
        chk(!out_valid && expq.size() == 0, "R10 all words delivered", out_valid, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule